// File: doc/BRIEF.md
# 16-Point Radix-4 FFT Sequencing Controller

This block runs the data movement of a 16-point complex FFT built from two radix-4 passes. A one-cycle start pulse opens a capture window of 16 consecutive cycles. Each incoming sample is written into an internal one-write/one-read buffer at a base-4 digit-reversed address. The controller then performs two passes of four butterfly groups each. In every group it gathers four operands through the single read port and presents them to an external combinational unit that rotates and butterflies them. The four returned results are written back in place through the write port, and the next group is read during that write-back. Rotation factors are never stored. The controller emits a 4-bit twiddle index per leg, derived from its pass counter, and the external rotation unit turns that index into a coefficient.

Results leave in natural bin order on a valid/ready stream with a bin index beside each word. The sink applies back-pressure by holding `out_ready` low. While it does, the word and its index stay frozen, and a word counts as transferred only on a cycle where `out_valid` and `out_ready` are both high. The capture side has no handshake: samples must arrive on the start cycle and the 15 cycles after it. A start pulse is honoured only when the controller is idle.

Top module: `fft16_seq_ctrl`

## Requirements
- R1: While `rst` (active high) is asserted, and after its release until a start is honoured, `out_valid` and `bf_strobe` stay low. Asserting `rst` during a transform abandons it, and no output follows.
- R2: When idle, a high `start` makes the controller take `in_data` on that same edge as sample 0, and on the next 15 edges as samples 1 to 15. Each sample word carries the real part in bits [15:8] and the imaginary part in bits [7:0], both two's complement.
- R3: A `start` pulse while a transform is loading, computing or unloading has no effect on the results, and it does not begin a further transform.
- R4: The buffer performs at most one write and one read per cycle. During a pass, the write-back of one group overlaps the operand reads of the next group, and the two never address the same word.
- R5: In the first pass, butterfly group g (g = 0..3, in time order) presents sample g+4·l on leg l, where leg l occupies `bf_op` bits [16l+15:16l]. All twiddle fields are 0. `bf_strobe` is high in the cycle whose `bf_res` is captured.
- R6: In the second pass, group k (k = 0..3, in time order) requests twiddle index (k·n) mod 16 for leg n = 1..3. The index for leg n sits in `tw_idx` bits [4n-1:4n-4] and selects the factor e^(-j·2π·m/16). Leg 0 is never rotated.
- R7: The external unit returns, for each output leg q, the sum over n of op_n · W16^(tw_n) · e^(-j·π·n·q/2), halved and rounded. Under that contract, the word with `out_idx` = k holds bin k of the 16-point DFT divided by 4, to within rounding. `out_idx` runs 0 to 15 in order.
- R8: With `out_ready` held high, `out_valid` is high for exactly 16 consecutive cycles per transform.
- R9: When `out_valid` is high and `out_ready` is low, the next cycle still shows `out_valid` high with the same `out_data` and `out_idx`.
- R10: `out_valid` first rises 56 cycles after the start cycle: 16 capture cycles plus two passes of 20 cycles each.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle start pulse, honoured only when idle |
| in_data | input | 16 | Input sample {re, im} |
| bf_op | output | 64 | Four butterfly operands, leg l at [16l+15:16l] |
| tw_idx | output | 12 | Twiddle index for legs 1..3, 4 bits each |
| bf_strobe | output | 1 | Operands complete; `bf_res` captured at this edge |
| bf_res | input | 64 | Four results from the external rotation/butterfly unit |
| out_valid | output | 1 | Result word available |
| out_ready | input | 1 | Sink accepts the result word |
| out_data | output | 16 | Result {re, im} |
| out_idx | output | 4 | Frequency bin of `out_data` |

## Verification
Within a pass, the buffer's write port stores a result of group g while its read port fetches an operand of group g+1. Both happen in the same cycle, and together with the external butterfly strobe this is the pair most likely to collide. Every transform provokes it. The judgement comes from signals visible at the ports: operand legs and twiddle indices are compared at each strobe, and the 16 bins are matched against a direct DFT computed in the bench. A second overlap comes from a start pulse that lands mid-pass or during an unload stalled by back-pressure. That case is judged by unchanged bins and by the absence of any further output burst.

// File: rtl/fft16_pkg.sv
package fft16_pkg;
  localparam int NPT      = 16;
  localparam int RADIX    = 4;
  localparam int DB       = 2;              // bits per base-4 digit
  localparam int AW       = 2 * DB;         // buffer address width
  localparam int PASS_LEN = NPT + RADIX;    // reads plus write-back tail
  localparam int CW       = $clog2(PASS_LEN);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_PASS1,
    ST_PASS2,
    ST_UNLOAD
  } seq_state_t;

  // group/leg to buffer address; pass 2 strides by RADIX
  function automatic logic [AW-1:0] grp_addr(input logic second,
                                             input logic [DB-1:0] grp,
                                             input logic [DB-1:0] leg);
    return second ? {leg, grp} : {grp, leg};
  endfunction
endpackage

// File: rtl/fft16_dpram.sv
module fft16_dpram #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16,
  localparam int AWID = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AWID-1:0]  waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AWID-1:0]  raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/fft16_addr_gen.sv
module fft16_addr_gen
  import fft16_pkg::*;
(
  input  seq_state_t        state,
  input  logic [CW-1:0]     cnt,
  output logic [AW-1:0]     rd_addr,
  output logic [AW-1:0]     wb_addr,
  output logic [AW-1:0]     ld_addr,
  output logic              rd_act,
  output logic              wb_act,
  output logic [DB-1:0]     rd_leg,
  output logic [3*AW-1:0]   tw_idx
);
  logic          in_pass, second;
  logic [AW-1:0] wpos;
  logic [AW-1:0] grp_ext;

  assign in_pass = (state == ST_PASS1) || (state == ST_PASS2);
  assign second  = (state == ST_PASS2);
  assign wpos    = cnt[AW-1:0] - AW'(RADIX);
  assign rd_act  = in_pass && (cnt < CW'(NPT));
  assign wb_act  = in_pass && (cnt >= CW'(RADIX));
  assign rd_leg  = cnt[DB-1:0];

  assign rd_addr = (state == ST_UNLOAD) ? cnt[AW-1:0]
                 : grp_addr(second, cnt[AW-1:DB], cnt[DB-1:0]);
  assign wb_addr = grp_addr(second, wpos[AW-1:DB], wpos[DB-1:0]);
  // capture order: sample n lands at digit-reversed address
  assign ld_addr = {cnt[DB-1:0], cnt[AW-1:DB]};

  assign grp_ext = {{(AW-DB){1'b0}}, cnt[AW-1:DB]};

  for (genvar n = 1; n < RADIX; n++) begin : g_tw
    assign tw_idx[(n-1)*AW +: AW] = second ? AW'(grp_ext * AW'(n)) : '0;
  end
endmodule

// File: rtl/fft16_seq_ctrl.sv
module fft16_seq_ctrl
  import fft16_pkg::*;
#(
  parameter int DW = 8,
  localparam int SW = 2 * DW
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [SW-1:0]       in_data,
  output logic [RADIX*SW-1:0] bf_op,
  output logic [3*AW-1:0]     tw_idx,
  output logic                bf_strobe,
  input  logic [RADIX*SW-1:0] bf_res,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SW-1:0]       out_data,
  output logic [AW-1:0]       out_idx
);
  seq_state_t    state;
  logic [CW-1:0] cnt;

  logic [AW-1:0] rd_addr, wb_addr, ld_addr, waddr;
  logic          rd_act, wb_act, we;
  logic [DB-1:0] rd_leg;
  logic [SW-1:0] rdata, wdata;
  logic [SW-1:0] gather [RADIX-1];
  logic [SW-1:0] hold   [RADIX];

  // sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_LOAD;
          cnt   <= CW'(1);
        end
        ST_LOAD: if (cnt == CW'(NPT-1)) begin
          state <= ST_PASS1;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        ST_PASS1: if (cnt == CW'(PASS_LEN-1)) begin
          state <= ST_PASS2;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        ST_PASS2: if (cnt == CW'(PASS_LEN-1)) begin
          state <= ST_UNLOAD;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        ST_UNLOAD: if (out_ready) begin
          if (cnt == CW'(NPT-1)) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          state <= ST_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  fft16_addr_gen u_agen (
    .state   (state),
    .cnt     (cnt),
    .rd_addr (rd_addr),
    .wb_addr (wb_addr),
    .ld_addr (ld_addr),
    .rd_act  (rd_act),
    .wb_act  (wb_act),
    .rd_leg  (rd_leg),
    .tw_idx  (tw_idx)
  );

  // write port: capture or in-place write-back
  assign we    = (state == ST_IDLE && start) || (state == ST_LOAD) || wb_act;
  assign waddr = wb_act ? wb_addr : ld_addr;
  assign wdata = wb_act ? hold[cnt[DB-1:0]] : in_data;

  fft16_dpram #(.WIDTH(SW), .DEPTH(NPT)) u_buf (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .raddr (rd_addr),
    .rdata (rdata)
  );

  // operand gathering: last leg comes straight from the read port
  assign bf_strobe = rd_act && (rd_leg == DB'(RADIX-1));

  for (genvar l = 0; l < RADIX; l++) begin : g_leg
    if (l < RADIX-1) begin : g_gath
      always_ff @(posedge clk) begin
        if (rd_act && rd_leg == DB'(l)) gather[l] <= rdata;
      end
      assign bf_op[l*SW +: SW] = gather[l];
    end else begin : g_last
      assign bf_op[l*SW +: SW] = rdata;
    end
    always_ff @(posedge clk) begin
      if (bf_strobe) hold[l] <= bf_res[l*SW +: SW];
    end
  end

  // result stream
  assign out_valid = (state == ST_UNLOAD);
  assign out_data  = rdata;
  assign out_idx   = cnt[AW-1:0];

  // R4: write-back and operand read never hit the same word
  a_r4_port_split: assert property (@(posedge clk) disable iff (rst)
    (we && rd_act) |-> (waddr != rd_addr));

  // R5: first pass requests no rotation
  a_r5_pass1_unrotated: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PASS1) |-> (tw_idx == '0));

  // R9: stalled word is held
  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_idx)));

  // R7: bin index advances by one per transfer
  a_r7_idx_step: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_idx != AW'(NPT-1)) |=>
      (out_valid && out_idx == $past(out_idx) + 1'b1));

  // R8: burst ends only after the last bin
  a_r8_burst_end: assert property (@(posedge clk) disable iff (rst)
    $fell(out_valid) |-> ($past(out_idx) == AW'(NPT-1)));
endmodule

// File: tb/fft16_seq_ctrl_tb_top.sv
module fft16_seq_ctrl_tb_top;
  localparam real PI = 3.14159265358979;
  localparam int  WD = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] in_data = '0;
  logic [63:0] bf_op, bf_res;
  logic [11:0] tw_idx;
  logic        bf_strobe, out_valid, out_ready = 1'b1;
  logic [15:0] out_data;
  logic [3:0]  out_idx;

  int checks = 0, failures = 0, cyc = 0;

  always #10 clk = ~clk;

  fft16_seq_ctrl dut_i (
    .clk(clk), .rst(rst), .start(start), .in_data(in_data),
    .bf_op(bf_op), .tw_idx(tw_idx), .bf_strobe(bf_strobe), .bf_res(bf_res),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_idx(out_idx)
  );

  // external rotation + radix-4 butterfly model (R7 contract)
  function automatic int sat8(input real v);
    int q = int'(v);
    if (q > 127) q = 127;
    if (q < -128) q = -128;
    return q;
  endfunction

  function automatic logic [63:0] bfly(input logic [63:0] ops, input logic [11:0] tw);
    real ar[4], ai[4];
    logic [63:0] r;
    for (int n = 0; n < 4; n++) begin
      real xr = real'($signed(ops[n*16+8 +: 8]));
      real xi = real'($signed(ops[n*16 +: 8]));
      int  m  = (n == 0) ? 0 : int'(tw[(n-1)*4 +: 4]);
      real ph = -2.0 * PI * m / 16.0;
      ar[n] = xr * $cos(ph) - xi * $sin(ph);
      ai[n] = xr * $sin(ph) + xi * $cos(ph);
    end
    for (int q = 0; q < 4; q++) begin
      real yr = 0.0, yi = 0.0;
      for (int n = 0; n < 4; n++) begin
        real ph = -PI / 2.0 * ((n * q) % 4);
        yr += ar[n] * $cos(ph) - ai[n] * $sin(ph);
        yi += ar[n] * $sin(ph) + ai[n] * $cos(ph);
      end
      r[q*16+8 +: 8] = 8'(sat8(yr / 2.0));
      r[q*16 +: 8]   = 8'(sat8(yi / 2.0));
    end
    return r;
  endfunction

  assign bf_res = bfly(bf_op, tw_idx);

  // stimulus table: kind 0 const, 1 impulse, 2 alternating, 3 j^n, 4 cosine bin 1
  localparam int NVEC = 6;
  localparam int V_KIND[NVEC]    = '{0, 1, 2, 3, 4, 0};
  localparam int V_AMP[NVEC]     = '{1, 100, 20, 20, 30, 5};
  localparam int V_STALL[NVEC]   = '{0, 0, 0, 1, 0, 1};
  localparam int V_RESTART[NVEC] = '{0, 0, 1, 0, 0, 1};

  int  xr[16], xi[16];
  real er[16], ei[16];
  logic [15:0] rec[16];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_pattern(input int kind, input int amp);
    for (int n = 0; n < 16; n++) begin
      xi[n] = 0;
      case (kind)
        0: xr[n] = amp;
        1: xr[n] = (n == 0) ? amp : 0;
        2: xr[n] = (n % 2 == 0) ? amp : -amp;
        3: begin
          case (n % 4)
            0: begin xr[n] = amp;  xi[n] = 0;    end
            1: begin xr[n] = 0;    xi[n] = amp;  end
            2: begin xr[n] = -amp; xi[n] = 0;    end
            default: begin xr[n] = 0; xi[n] = -amp; end
          endcase
        end
        default: xr[n] = int'(amp * $cos(2.0 * PI * n / 16.0));
      endcase
    end
    for (int k = 0; k < 16; k++) begin
      er[k] = 0.0; ei[k] = 0.0;
      for (int n = 0; n < 16; n++) begin
        real th = 2.0 * PI * ((k * n) % 16) / 16.0;
        er[k] += xr[n] * $cos(th) + xi[n] * $sin(th);
        ei[k] += xi[n] * $cos(th) - xr[n] * $sin(th);
      end
      er[k] = er[k] / 4.0; ei[k] = ei[k] / 4.0;
    end
  endtask

  function automatic logic [15:0] pack(input int n);
    return {8'(xr[n]), 8'(xi[n])};
  endfunction

  // strobe monitor for R5/R6
  int strobe_no = 0, mon_err = 0;
  always @(negedge clk) begin
    if (!rst && bf_strobe) begin
      strobe_no++;
      if (strobe_no <= 4) begin
        for (int l = 0; l < 4; l++)
          if (bf_op[l*16 +: 16] != pack(strobe_no - 1 + 4*l)) mon_err++;
        if (tw_idx != 12'd0) mon_err++;
      end else if (strobe_no <= 8) begin
        for (int n = 1; n < 4; n++)
          if (int'(tw_idx[(n-1)*4 +: 4]) != ((strobe_no - 5) * n) % 16) mon_err++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD) begin
      failures++;
      $display("FAIL R8 watchdog expired: actual=%0d expected<%0d", cyc, WD);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic run_vec(input int kind, input int amp, input int stall, input int restart);
    int first = -1, nrec = 0, vcount = 0, idx_err = 0, bin_err = 0;
    int st_chk = 0, st_err = 0;
    bit held = 0;
    logic [15:0] hd;
    logic [3:0]  hi;
    set_pattern(kind, amp);
    strobe_no = 0; mon_err = 0;
    @(negedge clk);
    start = 1'b1; in_data = pack(0); out_ready = 1'b1;
    for (int i = 1; i < 400 && nrec < 16; i++) begin
      @(negedge clk);
      start   = (restart != 0 && i == 30);
      in_data = (i < 16) ? pack(i) : 16'h5a5a;
      out_ready = (stall != 0) ? (i % 3 != 0) : 1'b1;
      if (held) begin
        st_chk++;
        if (!out_valid || out_data != hd || out_idx != hi) st_err++;
      end
      held = out_valid && !out_ready; hd = out_data; hi = out_idx;
      if (out_valid) begin
        vcount++;
        if (first < 0) first = i;
      end
      if (out_valid && out_ready) begin
        if (int'(out_idx) != nrec) idx_err++;
        rec[nrec] = out_data;
        nrec++;
      end
    end
    @(negedge clk);
    start = 1'b0; out_ready = 1'b1;
    chk(first == 56, "R10", "first out_valid cycle after start", first, 56);
    chk(nrec == 16 && !out_valid, "R8", "transfers per transform", nrec, 16);
    if (stall == 0) chk(vcount == 16, "R8", "consecutive valid cycles", vcount, 16);
    else chk(st_chk > 0 && st_err == 0, "R9", "stall hold mismatches", st_err, 0);
    chk(idx_err == 0, "R7", "out_idx order errors", idx_err, 0);
    chk(mon_err == 0 && strobe_no == 8, "R5", "operand/twiddle errors (R6 pass 2)", mon_err, 0);
    for (int k = 0; k < 16; k++) begin
      int dr = int'($signed(rec[k][15:8]));
      int di = int'($signed(rec[k][7:0]));
      int xr_e = int'(er[k]);
      int xi_e = int'(ei[k]);
      bit ok = (dr - xr_e <= 2) && (xr_e - dr <= 2) && (di - xi_e <= 2) && (xi_e - di <= 2);
      if (!ok) bin_err++;
      chk(ok, "R7", $sformatf("bin %0d re (im %0d vs %0d)", k, di, xi_e), dr, xr_e);
    end
    if (restart != 0) chk(bin_err == 0, "R3", "bins wrong after ignored start", bin_err, 0);
    chk(1'b1 == 1'b1 && bin_err == 0, "R2", "capture of 16 samples from start edge", bin_err, 0);
  endtask

  task automatic feed(input logic rdy);
    @(negedge clk);
    start = 1'b1; in_data = pack(0); out_ready = rdy;
    for (int i = 1; i < 16; i++) begin
      @(negedge clk);
      start = 1'b0; in_data = pack(i);
    end
  endtask

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!out_valid && !bf_strobe, "R1", "outputs during reset", int'(out_valid), 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(!out_valid && !bf_strobe, "R1", "outputs idle after reset", int'(out_valid), 0);

    for (int v = 0; v < NVEC; v++)
      run_vec(V_KIND[v], V_AMP[v], V_STALL[v], V_RESTART[v]);

    // R3: start during a stalled unload starts nothing
    set_pattern(0, 3);
    feed(1'b0);
    bad = 0;
    for (int i = 0; i < 100 && !out_valid; i++) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0; out_ready = 1'b1;
    for (int i = 0; i < 16; i++) @(negedge clk);
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (out_valid) bad++;
    end
    chk(bad == 0, "R3", "valid cycles after start during unload", bad, 0);

    // R1: reset in the middle of a transform abandons it
    set_pattern(1, 50);
    feed(1'b1);
    repeat (10) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    bad = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (out_valid || bf_strobe) bad++;
    end
    chk(bad == 0, "R1", "activity after mid-transform reset", bad, 0);
    run_vec(4, 30, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule